// File: doc/BRIEF.md
# Comma Word Aligner

This block sits behind a clock-recovery front end and takes one received bit per asserted bit enable. It keeps a two-word history of the stream. At every bit it looks for the positive-disparity comma, whose first seven bits in arrival order are 0,0,1,1,1,1,1. When alignment is enabled and a comma completes, the block selects a new word boundary so that the comma comes out whole, with bit 0 holding the earliest bit. The word strobe comes from a free-running count of ten accepted bits, so it keeps its cadence through any realignment.

When alignment is disabled, the boundary stays where it was and the comma flag is forced low. Repeated commas at the same offset leave the boundary alone. The flag stays high on every one of those words.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `word_out` is 0, and `word_stb` and `comma_flag` are low.
- R2: `word_stb` is a one-clock pulse. It comes in the clock after every tenth accepted bit, counted from reset. `word_out` changes only together with a strobe.
- R3: Bit 0 of `word_out` holds the earliest received bit of the word and bit 9 the latest.
- R4: A comma is any word whose bits 0..6 are 0,0,1,1,1,1,1; bits 7..9 can take any value. With alignment enabled, a comma is found at any bit offset. Number the accepted bits from 0 since reset and let the comma's first bit be number c. The comma is then output intact on strobe number (c+9)/10, counting strobes from 0.
- R5: Once aligned, the words that follow a comma come out intact and in order on the following strobes.
- R6: `comma_flag` is high exactly while alignment is enabled and the word being output is a comma.
- R7: With alignment disabled, `comma_flag` stays low and a comma at a new offset does not move the word boundary.
- R8: A change of `align_en` shows on `comma_flag` within 3 word periods.
- R9: Back-to-back commas keep the same boundary and lose no strobe, and the flag stays high on each of them.
- R10: A comma at an offset different from the current one moves the boundary. The next strobe still comes exactly ten bits after the previous one.
- R11: Clocks with `bit_en` low change nothing at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` for one clock |
| bit_in | input | 1 | Received serial bit |
| align_en | input | 1 | Enables comma search and the comma flag |
| word_out | output | 10 | Aligned word, bit 0 received first |
| word_stb | output | 1 | One-clock pulse marking a new word |
| comma_flag | output | 1 | High while the output word is a comma and alignment is enabled |

## Verification
The hardest case to reach is a realignment while the current boundary is in use. It needs a stream already locked at one offset, then a comma shifted by a few bits. The bench first locks with a short prefix. It then inserts a three-bit slip with alignment disabled, to show that the boundary holds, and a four-bit slip with alignment enabled, to show the move. It tracks the bit count so that the exact strobe carrying each comma is known in advance.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    localparam int WORD_W = 10;
    localparam int MARK_W = 7;
    // bit 0 (earliest) is the rightmost digit
    localparam logic [MARK_W-1:0] MARK_BITS = 7'b1111100;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              mark;
    } out_word_t;

    function automatic logic has_mark(input logic [MARK_W-1:0] head);
        return head == MARK_BITS;
    endfunction

endpackage

// File: rtl/cwa_history.sv
module cwa_history #(
    parameter int W = cwa_pkg::WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_en,
    input  logic           bit_in,
    output logic [2*W-1:0] hist_nxt,
    output logic           mark_hit
);
    localparam int HW = 2 * W;

    logic [HW-1:0] hist_q;

    // newest bit enters at the top, so older bits sit at lower indices
    always_comb begin
        hist_nxt = bit_en ? {bit_in, hist_q[HW-1:1]} : hist_q;
        mark_hit = bit_en && cwa_pkg::has_mark(hist_nxt[W +: cwa_pkg::MARK_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_nxt;
    end

endmodule

// File: rtl/cwa_phase.sv
module cwa_phase #(
    parameter int W = cwa_pkg::WORD_W,
    localparam int PH_W  = $clog2(W),
    localparam int OFF_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             mark_hit,
    input  logic             align_en,
    output logic             word_end,
    output logic [OFF_W-1:0] sel_off
);
    logic [PH_W-1:0]  ph_q;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] off_c;

    always_comb begin
        off_c = off_q;
        if (mark_hit && align_en)
            off_c = OFF_W'(ph_q) + OFF_W'(1);
        word_end = bit_en && (ph_q == PH_W'(W - 1));
        sel_off  = off_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            off_q <= OFF_W'(W);
        end else if (bit_en) begin
            ph_q  <= word_end ? '0 : ph_q + PH_W'(1);
            off_q <= off_c;
        end
    end

    // R10: the window offset always lies inside the history
    a_r10_offset_range: assert property (@(posedge clk) disable iff (rst)
        (sel_off >= OFF_W'(1)) && (sel_off <= OFF_W'(W)));

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
    parameter int W = cwa_pkg::WORD_W,
    localparam int OFF_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en,
    input  logic         bit_in,
    input  logic         align_en,
    output logic [W-1:0] word_out,
    output logic         word_stb,
    output logic         comma_flag
);
    import cwa_pkg::*;

    logic [2*W-1:0]   hist_nxt;
    logic             mark_hit;
    logic             word_end;
    logic [OFF_W-1:0] sel_off;
    logic [W-1:0]     cand [1:W];
    logic [W-1:0]     pick;
    out_word_t        out_q;
    logic             stb_q;

    cwa_history #(.W(W)) u_hist (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .hist_nxt(hist_nxt), .mark_hit(mark_hit)
    );

    cwa_phase #(.W(W)) u_phase (
        .clk(clk), .rst(rst), .bit_en(bit_en), .mark_hit(mark_hit),
        .align_en(align_en), .word_end(word_end), .sel_off(sel_off)
    );

    for (genvar o = 1; o <= W; o++) begin : g_win
        assign cand[o] = hist_nxt[o +: W];
    end

    always_comb pick = cand[sel_off];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= word_end;
            if (word_end) begin
                out_q.data <= pick;
                out_q.mark <= align_en && has_mark(pick[MARK_W-1:0]);
            end
        end
    end

    assign word_out   = out_q.data;
    assign comma_flag = out_q.mark;
    assign word_stb   = stb_q;

    // ---- checks ----
    logic [7:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (rst)                gap_cnt <= '0;
        else if (word_stb)      gap_cnt <= {7'd0, bit_en};
        else if (bit_en && gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 8'd1;
    end

    // R2, R10: strobes are spaced by exactly one word of accepted bits
    a_r2_stb_spacing: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> (gap_cnt == 8'(W)));

    a_r2_stb_pulse: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);

    a_r2_word_hold: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(word_out));

    a_r7_flag_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(comma_flag) |-> $past(align_en));

    a_r6_flag_pattern: assert property (@(posedge clk) disable iff (rst)
        comma_flag |-> (word_out[MARK_W-1:0] == MARK_BITS));

endmodule

// File: tb/sim_comma_word_aligner.sv
module sim_comma_word_aligner;
    localparam int CLK_P = 10;
    localparam logic [9:0] COMMA_A = 10'h17C;
    localparam logic [9:0] COMMA_B = 10'h0FC;
    // columns: prefix bits, commas, data words, align enable, expected comma strobe
    localparam int VEC [0:5][0:4] = '{
        '{0, 1, 3, 1, 0},
        '{3, 2, 3, 1, 1},
        '{7, 3, 2, 1, 1},
        '{11, 1, 4, 1, 2},
        '{5, 2, 2, 0, 1},
        '{19, 1, 2, 1, 2}
    };

    logic clk = 0, rst = 1, bit_en = 0, bit_in = 0, align_en = 0;
    logic [9:0] word_out;
    logic word_stb, comma_flag;

    int nchk = 0, nfail = 0, nbits = 0, nstb = 0;
    logic [9:0] ow [0:63];
    logic       of [0:63];

    comma_word_aligner u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .align_en(align_en), .word_out(word_out), .word_stb(word_stb),
        .comma_flag(comma_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] dw(input int i);
        return 10'h155 ^ (10'h1 << ((3 * i + 1) % 10));
    endfunction

    function automatic logic [9:0] cw(input int i);
        return (i % 2 == 0) ? COMMA_A : COMMA_B;
    endfunction

    always @(negedge clk) begin
        if (!rst && word_stb) begin
            if (nstb < 64) begin
                ow[nstb] = word_out;
                of[nstb] = comma_flag;
            end
            chk(nbits == 10 * (nstb + 1), "R2 spacing", nbits, 10 * (nstb + 1));
            nstb++;
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b; bit_en = 1; nbits++;
        @(negedge clk);
        bit_en = 0;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int b = 0; b < 10; b++) send_bit(w[b]);
    endtask

    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) send_bit(~i[0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; bit_en = 0;
        repeat (3) @(negedge clk);
        chk(word_out == 0 && !word_stb && !comma_flag, "R1 during reset", word_out, 0);
        nbits = 0; nstb = 0;
        rst = 0;
        @(negedge clk);
        chk(word_out == 0 && !word_stb && !comma_flag, "R1 after reset", word_out, 0);
    endtask

    task automatic run_case(input int pre, input int ncom, input int ndat, input int en, input int s);
        int total;
        do_reset();
        align_en = en[0];
        send_junk(pre);
        for (int c = 0; c < ncom; c++) send_word(cw(c));
        for (int d = 0; d < ndat; d++) send_word(dw(d));
        send_junk(10);
        repeat (3) @(negedge clk);
        total = pre + 10 * (ncom + ndat) + 10;
        chk(nstb == total / 10, "R2 strobe count", nstb, total / 10);
        if (en != 0) begin
            for (int i = 0; i < s; i++) chk(of[i] == 0, "R6 prefix flag", of[i], 0);
            for (int c = 0; c < ncom; c++) begin
                chk(ow[s + c] == cw(c), "R4 comma word", ow[s + c], cw(c));
                chk(of[s + c] == 1, (ncom > 1) ? "R9 flag run" : "R6 flag", of[s + c], 1);
            end
            for (int d = 0; d < ndat; d++) begin
                chk(ow[s + ncom + d] == dw(d), "R5 R3 data word", ow[s + ncom + d], dw(d));
                chk(of[s + ncom + d] == 0, "R6 data flag", of[s + ncom + d], 0);
            end
        end else begin
            for (int i = 0; i < nstb; i++) chk(of[i] == 0, "R7 flag low", of[i], 0);
        end
    endtask

    initial begin
        int cs;
        // R11: idle clocks move nothing
        do_reset();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); bit_in = i[0];
        end
        repeat (2) @(negedge clk);
        chk(nstb == 0 && word_out == 0, "R11 idle", nstb, 0);

        for (int v = 0; v < 6; v++)
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

        // R8: enable toggled during a comma run
        do_reset();
        align_en = 0;
        for (int c = 0; c < 3; c++) send_word(COMMA_A);
        align_en = 1;
        for (int c = 0; c < 4; c++) send_word(COMMA_A);
        align_en = 0;
        for (int c = 0; c < 4; c++) send_word(COMMA_A);
        send_junk(10);
        repeat (3) @(negedge clk);
        chk(of[0] == 0 && of[1] == 0 && of[2] == 0, "R7 disabled flags", of[2], 0);
        chk(of[5] == 1, "R8 enable rise", of[5], 1);
        chk(of[9] == 0, "R8 enable fall", of[9], 0);

        // R7 and R10: slip while disabled holds, slip while enabled moves
        do_reset();
        align_en = 1;
        send_junk(2);
        send_word(COMMA_A);
        send_word(dw(0)); send_word(dw(1));
        align_en = 0;
        send_junk(3);
        cs = nbits;
        send_word(COMMA_A);
        send_word(dw(2)); send_word(dw(3));
        repeat (3) @(negedge clk);
        chk(ow[(cs + 9) / 10][6:0] != COMMA_A[6:0], "R7 boundary kept", ow[(cs + 9) / 10], 0);
        chk(of[(cs + 9) / 10] == 0, "R7 flag low", of[(cs + 9) / 10], 0);
        align_en = 1;
        send_junk(4);
        cs = nbits;
        send_word(COMMA_B);
        send_word(dw(4)); send_word(dw(5));
        send_junk(10);
        repeat (3) @(negedge clk);
        chk(ow[(cs + 9) / 10] == COMMA_B, "R10 realigned comma", ow[(cs + 9) / 10], COMMA_B);
        chk(of[(cs + 9) / 10] == 1, "R10 realigned flag", of[(cs + 9) / 10], 1);
        chk(ow[(cs + 9) / 10 + 1] == dw(4), "R10 data after", ow[(cs + 9) / 10 + 1], dw(4));
        chk(ow[(cs + 9) / 10 + 2] == dw(5), "R10 data after", ow[(cs + 9) / 10 + 2], dw(5));
        chk(nstb == nbits / 10, "R10 no lost strobe", nstb, nbits / 10);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule